// File: doc/BRIEF.md
# Power-Good and Reset-Delay Supervisor

This block turns per-channel status from a multi-output regulator into three supervisory signals. Each channel reports whether it has reached its target level and whether it is faulted. A channel is good only when it is at target and not faulted. A channel-select mask picks which channels take part. The power-good output is the AND of the good status of every selected channel, and it is forced low when no channel is selected.

A second output, `delayed_ok`, copies power-good after a programmable hold-off. The hold-off is counted in millisecond ticks, from 0 to 255. It falls in the same cycle that power-good falls. On every new rise of power-good the count starts again from zero. A third output flags low supply using two comparator levels, which gives it hysteresis. It sets when the supply drops below the fault level. It clears only after the supply has risen above the higher warning level.

All three outputs are registered inside the block. Routing them to pins is the job of a separate block.

Top module: `pgood_supervisor`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `power_ok` and `delayed_ok` go low and `low_vcc` goes high.
- R2: A selected channel holds `power_ok` low if `ch_at_target` is 0 for it or `ch_fault` is 1 for it. `power_ok` is registered and responds one clock after the inputs change.
- R3: `power_ok` is 1 exactly when every channel whose `ch_mask` bit is 1 has `ch_at_target`=1 and `ch_fault`=0. The status of channels whose mask bit is 0 has no effect.
- R4: When `ch_mask` is all zeros, `power_ok` is 0 no matter what the channel status is.
- R5: With `delay_ms`=N>0, `delayed_ok` rises on the clock after the N-th `ms_tick` that is sampled while `power_ok` is 1.
- R6: With `delay_ms`=0, `delayed_ok` rises one clock after `power_ok` rises.
- R7: `delayed_ok` is 0 in every cycle in which `power_ok` is 0. A fall of `power_ok` clears the hold-off count, so the next rise of `power_ok` waits the full N ticks again.
- R8: The hold-off count advances only on cycles where `ms_tick` is 1. Cycles without a tick leave it unchanged.
- R9: `uv_fault_cmp`=1 (supply below the fault level) sets `low_vcc` to 1 on the next clock.
- R10: When `uv_fault_cmp`=0 and `uv_warn_cmp`=1 (supply between the two levels), `low_vcc` keeps its value. It clears to 0 only when both comparator bits are 0.
- R11: The largest setting, `delay_ms`=255, needs 255 qualifying ticks before `delayed_ok` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_at_target | input | NUM_CH | Per-channel: 1 when the output has reached its target |
| ch_fault | input | NUM_CH | Per-channel: 1 when the channel is faulted |
| ch_mask | input | NUM_CH | 1 selects the channel for power-good |
| uv_fault_cmp | input | 1 | 1 when the supply is below the fault level |
| uv_warn_cmp | input | 1 | 1 when the supply is below the warning level |
| ms_tick | input | 1 | One-cycle pulse, once per millisecond |
| delay_ms | input | DLY_W | Hold-off in milliseconds (0 to 255) |
| power_ok | output | 1 | AND of the good status of the selected channels |
| delayed_ok | output | 1 | `power_ok` after the hold-off |
| low_vcc | output | 1 | Low-supply flag with hysteresis |

## Verification
A stale or wrong hold-off count shows up at `delayed_ok`. It rises one or more ticks early or late after a power-good drop and recovery, so the bench drops power-good partway through a count and checks the full wait afterwards. A low-supply flag that has lost its held state shows up in the first cycle the supply sits between the two levels. For that reason the bench holds that band both after a fault and after a clear. Each output is compared every clock against a reference model, so any error is reported in the cycle it first appears.

// File: rtl/pgood_pkg.sv
// Package: shared widths and types for the power-good supervisor.
// Assumes an 8-bit millisecond hold-off setting.
package pgood_pkg;
    localparam int DLY_W = 8;
    typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/pgood_chan_and.sv
// Module: pgood_chan_and
// Forms each channel's good bit (at target and not faulted) and registers the
// AND across the selected channels. An empty mask gives a low result.
// Assumes all inputs are synchronous to clk.
module pgood_chan_and #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] at_target,
    input  logic [NUM_CH-1:0] faulted,
    input  logic [NUM_CH-1:0] sel,
    output logic              ok_q
);
    logic [NUM_CH-1:0] pass_vec;
    logic              any_sel;

    // Per-channel pass: good, or not selected.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb pass_vec[g] = ~sel[g] | (at_target[g] & ~faulted[g]);
    end

    // Detect whether at least one channel is selected.
    always_comb any_sel = |sel;

    // Register the combined power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= any_sel & (&pass_vec);
    end

    p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> !ok_q);
    p_fault_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel & (faulted | ~at_target)) != '0) |=> !ok_q);
endmodule

// File: rtl/pgood_holdoff.sv
// Module: pgood_holdoff
// Counts millisecond ticks while power-good is high and sets a done flag once
// the programmed count is reached. The count and the flag clear in the cycle
// after power-good is seen low. Assumes ms_tick is a one-cycle pulse.
module pgood_holdoff
    import pgood_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ok_in,
    input  logic tick,
    input  dly_t dly,
    output logic done_q
);
    dly_t             cnt_q;
    logic [DLY_W:0]   cnt_next;

    // Value the counter would take on a qualifying tick.
    always_comb cnt_next = {1'b0, cnt_q} + 1'b1;

    // Hold-off counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !ok_in) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (dly == '0) begin
                done_q <= 1'b1;
            end else if (tick) begin
                cnt_q <= cnt_next[DLY_W-1:0];
                if (cnt_next >= {1'b0, dly}) done_q <= 1'b1;
            end
        end
    end

    p_count_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_in && !tick) |=> $stable(cnt_q));
    p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_in && dly == '0) |=> done_q);
    p_clear_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_in |=> (!done_q && cnt_q == '0));
endmodule

// File: rtl/pgood_lowvcc.sv
// Module: pgood_lowvcc
// Low-supply flag with hysteresis from two comparators. The fault comparator
// sets it, and both comparators idle clear it. Resets to the asserted state.
module pgood_lowvcc (
    input  logic clk,
    input  logic rst_n,
    input  logic below_fault,
    input  logic below_warn,
    output logic low_q
);
    // Set on fault, clear above warning level, hold in between.
    always_ff @(posedge clk) begin
        if (!rst_n)           low_q <= 1'b1;
        else if (below_fault) low_q <= 1'b1;
        else if (!below_warn) low_q <= 1'b0;
    end

    p_fault_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        below_fault |=> low_q);
    p_band_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_fault && below_warn) |=> $stable(low_q));
endmodule

// File: rtl/pgood_supervisor.sv
// Module: pgood_supervisor (top)
// Builds power-good, the delayed power-good and the low-supply flag from
// per-channel regulator status. The delayed output is gated by power-good, so
// it drops in the same cycle power-good drops.
module pgood_supervisor
    import pgood_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_at_target,
    input  logic [NUM_CH-1:0] ch_fault,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic              uv_fault_cmp,
    input  logic              uv_warn_cmp,
    input  logic              ms_tick,
    input  logic [DLY_W-1:0]  delay_ms,
    output logic              power_ok,
    output logic              delayed_ok,
    output logic              low_vcc
);
    logic ok_w;
    logic done_w;

    pgood_chan_and #(.NUM_CH(NUM_CH)) u_and (
        .clk(clk), .rst_n(rst_n), .at_target(ch_at_target),
        .faulted(ch_fault), .sel(ch_mask), .ok_q(ok_w)
    );

    pgood_holdoff u_hold (
        .clk(clk), .rst_n(rst_n), .ok_in(ok_w), .tick(ms_tick),
        .dly(delay_ms), .done_q(done_w)
    );

    pgood_lowvcc u_low (
        .clk(clk), .rst_n(rst_n), .below_fault(uv_fault_cmp),
        .below_warn(uv_warn_cmp), .low_q(low_vcc)
    );

    // Drive the outputs; the delayed output is qualified by power-good.
    always_comb begin
        power_ok   = ok_w;
        delayed_ok = ok_w & done_w;
    end

    p_rise_after_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delayed_ok) |-> $past(ok_w));
endmodule

// File: tb/pgood_supervisor_bench.sv
module pgood_supervisor_bench;
    localparam int NCH = 4;
    typedef struct { logic ok; logic dok; logic low; string tag; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] tgt = '0, flt = '0, msk = '0;
    logic uvf = 1'b0, uvw = 1'b0, tick = 1'b0;
    logic [7:0] dly = '0;
    logic ok_o, dok_o, low_o;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    bit m_ok = 0, m_done = 0, m_low = 1;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    pgood_supervisor #(.NUM_CH(NCH)) u_pgood_supervisor (
        .clk(clk), .rst_n(rst_n), .ch_at_target(tgt), .ch_fault(flt),
        .ch_mask(msk), .uv_fault_cmp(uvf), .uv_warn_cmp(uvw), .ms_tick(tick),
        .delay_ms(dly), .power_ok(ok_o), .delayed_ok(dok_o), .low_vcc(low_o)
    );

    // Driver: inputs already set; compute the expected post-edge outputs.
    task automatic step(input string tag);
        exp_t e;
        bit nok;
        if (!rst_n) begin
            m_ok = 0; m_done = 0; m_cnt = 0; m_low = 1;
        end else begin
            nok = (msk != 0);
            for (int i = 0; i < NCH; i++)
                if (msk[i] && !(tgt[i] && !flt[i])) nok = 0;
            if (!m_ok) begin m_cnt = 0; m_done = 0; end
            else if (!m_done) begin
                if (dly == 0) m_done = 1;
                else if (tick) begin m_cnt++; if (m_cnt >= dly) m_done = 1; end
            end
            m_ok = nok;
            if (uvf) m_low = 1; else if (!uvw) m_low = 0;
        end
        e.ok = m_ok; e.dok = m_ok & m_done; e.low = m_low; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n, input int tick_every, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = (tick_every > 0) && ((i % tick_every) == tick_every - 1);
            step(tag);
        end
        tick = 0;
    endtask

    // Monitor: compare outputs just after each edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0 && !finished) begin
            e = q.pop_front();
            checks++;
            if (ok_o !== e.ok || dok_o !== e.dok || low_o !== e.low) begin
                errors++;
                $display("FAIL %s: actual ok=%b dok=%b low=%b expected ok=%b dok=%b low=%b",
                         e.tag, ok_o, dok_o, low_o, e.ok, e.dok, e.low);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state with active-looking inputs
        tgt = '1; msk = 4'b0101; uvw = 1;
        run(3, 0, "R1");
        rst_n = 1;
        // R6 zero delay, R3 masked AND
        dly = 0; uvw = 0;
        run(4, 0, "R6");
        // R3 unmasked channel status ignored
        flt = 4'b0010; tgt = 4'b0111;
        run(3, 0, "R3");
        // R2 fault on selected channel, R7 delayed drops too
        flt = 4'b0001;
        run(3, 0, "R2");
        flt = 0; tgt = 4'b1011;
        run(3, 0, "R2");
        tgt = '1;
        // R4 empty mask
        msk = 0;
        run(3, 0, "R4");
        // R5 / R8 delay of 3 with sparse ticks
        dly = 3; msk = 4'b1111;
        run(16, 4, "R5");
        // R7 drop midway then full restart
        flt = 4'b1000; run(2, 0, "R7");
        flt = 0; run(6, 3, "R7");
        flt = 4'b1000; run(2, 0, "R7");
        flt = 0; run(14, 3, "R8");
        // R11 max delay with a tick each cycle
        flt = 4'b0100; run(2, 0, "R11");
        dly = 8'd255; flt = 0;
        run(262, 1, "R11");
        // R9 / R10 low supply hysteresis
        uvf = 1; uvw = 1; run(2, 0, "R9");
        uvf = 0; run(3, 0, "R10");
        uvw = 0; run(2, 0, "R10");
        uvw = 1; run(3, 0, "R10");
        uvf = 1; run(2, 0, "R9");
        uvf = 0; uvw = 0; run(2, 0, "R10");
        // R1 reset again mid-operation
        rst_n = 0; run(2, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule